// File: doc/BRIEF.md
# Serial NAND Page Reader

This block fetches one page from a serial NAND device and returns the bytes a caller asked for. It does not drive the serial pins itself. It hands a sequence of frame descriptors to an external frame engine. Each descriptor carries an opcode, an address and its byte count, the lane widths, a dummy count and a receive length. The engine hands back received bytes and an end-of-frame pulse.

A read runs in three phases. First, a load command moves the addressed row into the device cache. Next, the status register is read repeatedly until the device reports it is no longer busy, and the two-bit ECC field of the last status byte is decoded. Last, a cache read fetches the requested column range using one of six IO variants. The variant sets the opcode, the address and data lane widths, and the dummy count, which comes from a per-variant configuration input.

When the read ends, a one-cycle done pulse carries a completion code: OK, corrected, uncorrectable or timeout. A poll limit bounds how long the block waits on a busy device.

Top module: `snand_page_reader`

## Requirements
- R1: `req_ready_o` is high only while the block is idle. A request taken with `req_valid_i` high in that state starts a load frame in the next cycle. A request offered while the block is busy is ignored and does not alter the read in progress.
- R2: The load frame has opcode 0x13, the 24-bit row as its address, 3 address bytes, single lanes, zero dummy and a receive length of zero.
- R3: After the load frame ends, a status frame is issued. It has opcode 0x0f, address 0xc0, 1 address byte, single lanes, zero dummy and a receive length of 1.
- R4: A status byte with bit 0 set (busy) is followed by another status frame, unless R5 applies.
- R5: The poll limit is sampled when the request is taken. When the count of busy status bytes reaches the larger of that limit and 1, the read ends with code 3 (timeout) and no cache frame is issued.
- R6: The cache frame opcode and lanes depend on the mode. The lanes are given as address lanes/data lanes, encoded 1, 2 or 4. Mode 0 is 0x03 (1/1). Mode 1 is 0x0b (1/1). Mode 2 is 0x3b (1/2). Mode 3 is 0x6b (1/4). Mode 4 is 0xbb (2/2). Mode 5 is 0xeb (4/4). Modes 6 and 7 behave as mode 0.
- R7: The cache frame dummy count for mode m (0..5) is `dummy_cfg_i[m*DUM_W +: DUM_W]`. Modes 6 and 7 use slice 0.
- R8: The cache frame address is the 16-bit column, zero-extended, with 2 address bytes. Its receive length is the requested length, and exactly that many bytes are streamed out.
- R9: `rd_valid_o` is high exactly in the cycles where `frm_rx_valid_i` is high during the cache frame's receive phase, with `rd_data_o` equal to `frm_rx_data_i`. Bytes received in other phases are not streamed.
- R10: The completion code of a read that is not a timeout comes from bits [5:4] of the final status byte. The value 0 gives code 0, 1 gives code 1, and 2 or 3 gives code 2. The data is streamed in every case. Status bits 7:6 and 3:1 have no effect.
- R11: `done_o` is a one-cycle pulse in the cycle after the final frame's `frm_end_i`. `code_o` is 0 whenever `done_o` is low. The block is idle in the cycle after the pulse.
- R12: While `frm_valid_o` is high and `frm_ready_i` is low, `frm_valid_o` and every frame field hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Read request strobe |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_row_i | input | 24 | Page row address |
| req_col_i | input | 16 | Start column inside the page |
| req_len_i | input | LEN_W | Number of bytes to return |
| req_mode_i | input | 3 | Cache read variant select |
| poll_limit_i | input | POLL_W | Maximum busy status reads |
| dummy_cfg_i | input | 6*DUM_W | Dummy count per variant, mode m in slice m |
| frm_valid_o | output | 1 | Frame descriptor valid |
| frm_ready_i | input | 1 | Engine takes the descriptor |
| frm_opcode_o | output | 8 | Command opcode |
| frm_addr_o | output | 24 | Address value, right-aligned |
| frm_addr_bytes_o | output | 2 | Number of address bytes |
| frm_addr_lanes_o | output | 3 | Address lane width (1, 2, 4) |
| frm_dummy_o | output | DUM_W | Dummy count |
| frm_data_lanes_o | output | 3 | Data lane width (1, 2, 4) |
| frm_data_len_o | output | LEN_W | Bytes to receive |
| frm_rx_valid_i | input | 1 | Received byte valid |
| frm_rx_data_i | input | 8 | Received byte |
| frm_end_i | input | 1 | Current frame finished |
| rd_valid_o | output | 1 | Page data byte valid |
| rd_data_o | output | 8 | Page data byte |
| done_o | output | 1 | Read complete pulse |
| code_o | output | 2 | Completion code, valid with done_o |

## Verification
The bench builds the block with LEN_W=6, DUM_W=4 and POLL_W=4. The short length field keeps every cache frame to a handful of bytes. The narrow poll limit makes the timeout edges cheap to reach: a limit of 0, and busy counts one below and exactly at the limit. A 4-bit dummy slice per mode, loaded with a distinct value in each slot, shows that each variant picks its own slot and that modes 6 and 7 fall back to slot 0.

// File: rtl/snand_rd_pkg.sv
package snand_rd_pkg;
  localparam int unsigned ROW_W     = 24;
  localparam int unsigned COL_W     = 16;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned NUM_MODES = 6;
  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned ECC_LO    = 4;

  localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
  localparam logic [7:0] OP_GET_FEAT  = 8'h0f;
  localparam logic [7:0] FEAT_STATUS  = 8'hc0;

  typedef enum logic [1:0] {
    RC_OK      = 2'd0,
    RC_FIXED   = 2'd1,
    RC_BAD     = 2'd2,
    RC_TIMEOUT = 2'd3
  } rd_code_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_LOAD_WAIT, ST_POLL,
    ST_POLL_WAIT, ST_CACHE, ST_CACHE_WAIT, ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic [2:0] addr_lanes;
    logic [2:0] data_lanes;
  } variant_t;

  function automatic variant_t variant_of(input logic [MODE_W-1:0] m);
    variant_t v;
    case (m)
      3'd1:    v = '{opcode: 8'h0b, addr_lanes: 3'd1, data_lanes: 3'd1};
      3'd2:    v = '{opcode: 8'h3b, addr_lanes: 3'd1, data_lanes: 3'd2};
      3'd3:    v = '{opcode: 8'h6b, addr_lanes: 3'd1, data_lanes: 3'd4};
      3'd4:    v = '{opcode: 8'hbb, addr_lanes: 3'd2, data_lanes: 3'd2};
      3'd5:    v = '{opcode: 8'heb, addr_lanes: 3'd4, data_lanes: 3'd4};
      default: v = '{opcode: 8'h03, addr_lanes: 3'd1, data_lanes: 3'd1};
    endcase
    return v;
  endfunction
endpackage

// File: rtl/snand_rd_variant.sv
module snand_rd_variant
  import snand_rd_pkg::*;
#(
  parameter int unsigned DUM_W = 5
) (
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [NUM_MODES*DUM_W-1:0] dummy_cfg_i,
  output variant_t                   var_o,
  output logic [DUM_W-1:0]           dummy_o
);
  logic [DUM_W-1:0]  dum_arr [NUM_MODES];
  logic [MODE_W-1:0] sel;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_slice
    assign dum_arr[g] = dummy_cfg_i[g*DUM_W +: DUM_W];
  end

  // unlisted modes fall back to the plain read slot
  assign sel     = (mode_i < MODE_W'(NUM_MODES)) ? mode_i : '0;
  assign var_o   = variant_of(sel);
  assign dummy_o = dum_arr[sel];
endmodule

// File: rtl/snand_rd_status.sv
module snand_rd_status
  import snand_rd_pkg::*;
(
  input  logic [7:0] stat_i,
  output logic       busy_o,
  output rd_code_e   ecc_code_o
);
  logic [1:0] ecc;
  logic       unused_bits;

  assign busy_o      = stat_i[BUSY_BIT];
  assign ecc         = stat_i[ECC_LO +: 2];
  assign unused_bits = ^{stat_i[7:6], stat_i[3:1]};

  always_comb begin
    case (ecc)
      2'd0:    ecc_code_o = RC_OK;
      2'd1:    ecc_code_o = RC_FIXED;
      default: ecc_code_o = RC_BAD; // 3 is reserved, reported as failure
    endcase
  end
endmodule

// File: rtl/snand_rd_seq.sv
module snand_rd_seq
  import snand_rd_pkg::*;
#(
  parameter int unsigned LEN_W  = 13,
  parameter int unsigned DUM_W  = 5,
  parameter int unsigned POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [MODE_W-1:0] req_mode_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic [MODE_W-1:0] mode_o,
  input  variant_t          var_i,
  input  logic [DUM_W-1:0]  dummy_i,
  output logic [7:0]        stat_o,
  input  logic              busy_i,
  input  rd_code_e          ecc_i,
  output logic              frm_valid_o,
  input  logic              frm_ready_i,
  output logic [7:0]        frm_opcode_o,
  output logic [ROW_W-1:0]  frm_addr_o,
  output logic [1:0]        frm_addr_bytes_o,
  output logic [2:0]        frm_addr_lanes_o,
  output logic [DUM_W-1:0]  frm_dummy_o,
  output logic [2:0]        frm_data_lanes_o,
  output logic [LEN_W-1:0]  frm_data_len_o,
  input  logic              frm_rx_valid_i,
  input  logic [7:0]        frm_rx_data_i,
  input  logic              frm_end_i,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              done_o,
  output logic [1:0]        code_o
);
  seq_state_e        state_q, state_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [LEN_W-1:0]  len_q;
  logic [MODE_W-1:0] mode_q;
  logic [POLL_W-1:0] lim_q, polls_q;
  logic [7:0]        stat_q;
  rd_code_e          code_q;
  logic              poll_rx, expired;

  assign poll_rx = (state_q == ST_POLL_WAIT) && frm_rx_valid_i;
  // status byte may arrive in the same cycle as the frame end
  assign stat_o  = poll_rx ? frm_rx_data_i : stat_q;
  assign expired = (polls_q >= lim_q);
  assign mode_o  = mode_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (req_valid_i) state_d = ST_LOAD;
      ST_LOAD:       if (frm_ready_i) state_d = ST_LOAD_WAIT;
      ST_LOAD_WAIT:  if (frm_end_i)   state_d = ST_POLL;
      ST_POLL:       if (frm_ready_i) state_d = ST_POLL_WAIT;
      ST_POLL_WAIT:
        if (frm_end_i) begin
          if (!busy_i)     state_d = ST_CACHE;
          else if (expired) state_d = ST_DONE;
          else              state_d = ST_POLL;
        end
      ST_CACHE:      if (frm_ready_i) state_d = ST_CACHE_WAIT;
      ST_CACHE_WAIT: if (frm_end_i)   state_d = ST_DONE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      mode_q  <= '0;
      lim_q   <= '0;
      polls_q <= '0;
      stat_q  <= '0;
      code_q  <= RC_OK;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        len_q   <= req_len_i;
        mode_q  <= req_mode_i;
        lim_q   <= poll_limit_i;
        polls_q <= '0;
        code_q  <= RC_OK;
      end
      if (state_q == ST_POLL && frm_ready_i) polls_q <= polls_q + POLL_W'(1);
      if (poll_rx) stat_q <= frm_rx_data_i;
      if (state_q == ST_POLL_WAIT && frm_end_i) begin
        if (!busy_i)      code_q <= ecc_i;
        else if (expired) code_q <= RC_TIMEOUT;
      end
    end
  end

  always_comb begin
    frm_valid_o      = 1'b0;
    frm_opcode_o     = '0;
    frm_addr_o       = '0;
    frm_addr_bytes_o = '0;
    frm_addr_lanes_o = 3'd1;
    frm_dummy_o      = '0;
    frm_data_lanes_o = 3'd1;
    frm_data_len_o   = '0;
    case (state_q)
      ST_LOAD: begin
        frm_valid_o      = 1'b1;
        frm_opcode_o     = OP_PAGE_LOAD;
        frm_addr_o       = row_q;
        frm_addr_bytes_o = 2'd3;
      end
      ST_POLL: begin
        frm_valid_o      = 1'b1;
        frm_opcode_o     = OP_GET_FEAT;
        frm_addr_o       = ROW_W'(FEAT_STATUS);
        frm_addr_bytes_o = 2'd1;
        frm_data_len_o   = LEN_W'(1);
      end
      ST_CACHE: begin
        frm_valid_o      = 1'b1;
        frm_opcode_o     = var_i.opcode;
        frm_addr_o       = ROW_W'(col_q);
        frm_addr_bytes_o = 2'd2;
        frm_addr_lanes_o = var_i.addr_lanes;
        frm_dummy_o      = dummy_i;
        frm_data_lanes_o = var_i.data_lanes;
        frm_data_len_o   = len_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_valid_o  = (state_q == ST_CACHE_WAIT) && frm_rx_valid_i;
  assign rd_data_o   = frm_rx_data_i;
  assign done_o      = (state_q == ST_DONE);
  assign code_o      = done_o ? code_q : RC_OK;
endmodule

// File: rtl/snand_page_reader.sv
module snand_page_reader
  import snand_rd_pkg::*;
#(
  parameter int unsigned LEN_W  = 13,
  parameter int unsigned DUM_W  = 5,
  parameter int unsigned POLL_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  output logic                       req_ready_o,
  input  logic [23:0]                req_row_i,
  input  logic [15:0]                req_col_i,
  input  logic [LEN_W-1:0]           req_len_i,
  input  logic [2:0]                 req_mode_i,
  input  logic [POLL_W-1:0]          poll_limit_i,
  input  logic [6*DUM_W-1:0]         dummy_cfg_i,
  output logic                       frm_valid_o,
  input  logic                       frm_ready_i,
  output logic [7:0]                 frm_opcode_o,
  output logic [23:0]                frm_addr_o,
  output logic [1:0]                 frm_addr_bytes_o,
  output logic [2:0]                 frm_addr_lanes_o,
  output logic [DUM_W-1:0]           frm_dummy_o,
  output logic [2:0]                 frm_data_lanes_o,
  output logic [LEN_W-1:0]           frm_data_len_o,
  input  logic                       frm_rx_valid_i,
  input  logic [7:0]                 frm_rx_data_i,
  input  logic                       frm_end_i,
  output logic                       rd_valid_o,
  output logic [7:0]                 rd_data_o,
  output logic                       done_o,
  output logic [1:0]                 code_o
);
  logic [MODE_W-1:0] mode;
  variant_t          var_sel;
  logic [DUM_W-1:0]  dummy;
  logic [7:0]        stat;
  logic              busy;
  rd_code_e          ecc_code;

  snand_rd_variant #(.DUM_W(DUM_W)) u_variant (
    .mode_i      (mode),
    .dummy_cfg_i (dummy_cfg_i),
    .var_o       (var_sel),
    .dummy_o     (dummy)
  );

  snand_rd_status u_status (
    .stat_i     (stat),
    .busy_o     (busy),
    .ecc_code_o (ecc_code)
  );

  snand_rd_seq #(.LEN_W(LEN_W), .DUM_W(DUM_W), .POLL_W(POLL_W)) u_seq (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_row_i        (req_row_i),
    .req_col_i        (req_col_i),
    .req_len_i        (req_len_i),
    .req_mode_i       (req_mode_i),
    .poll_limit_i     (poll_limit_i),
    .mode_o           (mode),
    .var_i            (var_sel),
    .dummy_i          (dummy),
    .stat_o           (stat),
    .busy_i           (busy),
    .ecc_i            (ecc_code),
    .frm_valid_o      (frm_valid_o),
    .frm_ready_i      (frm_ready_i),
    .frm_opcode_o     (frm_opcode_o),
    .frm_addr_o       (frm_addr_o),
    .frm_addr_bytes_o (frm_addr_bytes_o),
    .frm_addr_lanes_o (frm_addr_lanes_o),
    .frm_dummy_o      (frm_dummy_o),
    .frm_data_lanes_o (frm_data_lanes_o),
    .frm_data_len_o   (frm_data_len_o),
    .frm_rx_valid_i   (frm_rx_valid_i),
    .frm_rx_data_i    (frm_rx_data_i),
    .frm_end_i        (frm_end_i),
    .rd_valid_o       (rd_valid_o),
    .rd_data_o        (rd_data_o),
    .done_o           (done_o),
    .code_o           (code_o)
  );
endmodule

// File: rtl/snand_page_reader_chk.sv
module snand_page_reader_chk #(
  parameter int unsigned LEN_W = 13,
  parameter int unsigned DUM_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             frm_valid_o,
  input logic             frm_ready_i,
  input logic [7:0]       frm_opcode_o,
  input logic [23:0]      frm_addr_o,
  input logic [1:0]       frm_addr_bytes_o,
  input logic [DUM_W-1:0] frm_dummy_o,
  input logic [LEN_W-1:0] frm_data_len_o,
  input logic             frm_rx_valid_i,
  input logic [7:0]       frm_rx_data_i,
  input logic             rd_valid_o,
  input logic [7:0]       rd_data_o,
  input logic             done_o,
  input logic [1:0]       code_o
);
  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> frm_valid_o && frm_opcode_o == 8'h13 && !req_ready_o);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !frm_valid_o && !rd_valid_o && !done_o);

  assert_load_shape_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && frm_opcode_o == 8'h13 |->
      frm_addr_bytes_o == 2'd3 && frm_dummy_o == '0 && frm_data_len_o == '0);

  assert_poll_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && frm_opcode_o == 8'h0f |->
      frm_addr_o == 24'hc0 && frm_addr_bytes_o == 2'd1 && frm_data_len_o == LEN_W'(1));

  assert_opcode_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o |-> (frm_opcode_o inside {8'h13, 8'h0f, 8'h03, 8'h0b, 8'h3b, 8'h6b, 8'hbb, 8'heb}));

  assert_stream_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> frm_rx_valid_i && rd_data_o == frm_rx_data_i && !frm_valid_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  assert_code_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> code_o == 2'd0);

  assert_frame_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_o && !frm_ready_i |=> frm_valid_o && $stable(frm_opcode_o) &&
      $stable(frm_addr_o) && $stable(frm_dummy_o) && $stable(frm_data_len_o));
endmodule

bind snand_page_reader snand_page_reader_chk #(.LEN_W(LEN_W), .DUM_W(DUM_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_valid_i      (req_valid_i),
  .req_ready_o      (req_ready_o),
  .frm_valid_o      (frm_valid_o),
  .frm_ready_i      (frm_ready_i),
  .frm_opcode_o     (frm_opcode_o),
  .frm_addr_o       (frm_addr_o),
  .frm_addr_bytes_o (frm_addr_bytes_o),
  .frm_dummy_o      (frm_dummy_o),
  .frm_data_len_o   (frm_data_len_o),
  .frm_rx_valid_i   (frm_rx_valid_i),
  .frm_rx_data_i    (frm_rx_data_i),
  .rd_valid_o       (rd_valid_o),
  .rd_data_o        (rd_data_o),
  .done_o           (done_o),
  .code_o           (code_o)
);

// File: tb/snand_page_reader_test.sv
module snand_page_reader_test;
  localparam int LEN_W  = 6;
  localparam int DUM_W  = 4;
  localparam int POLL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [23:0]       req_row = '0;
  logic [15:0]       req_col = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [2:0]        req_mode = '0;
  logic [POLL_W-1:0] poll_lim = '0;
  logic [6*DUM_W-1:0] dummy_cfg = 24'h765432;
  logic              frm_valid;
  logic              frm_ready = 1'b0;
  logic [7:0]        frm_opcode;
  logic [23:0]       frm_addr;
  logic [1:0]        frm_abytes;
  logic [2:0]        frm_alanes;
  logic [DUM_W-1:0]  frm_dummy;
  logic [2:0]        frm_dlanes;
  logic [LEN_W-1:0]  frm_len;
  logic              frm_rx_valid = 1'b0;
  logic [7:0]        frm_rx_data = '0;
  logic              frm_end = 1'b0;
  logic              rd_valid;
  logic [7:0]        rd_data;
  logic              done;
  logic [1:0]        code;

  snand_page_reader #(.LEN_W(LEN_W), .DUM_W(DUM_W), .POLL_W(POLL_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_row_i(req_row), .req_col_i(req_col), .req_len_i(req_len), .req_mode_i(req_mode),
    .poll_limit_i(poll_lim), .dummy_cfg_i(dummy_cfg),
    .frm_valid_o(frm_valid), .frm_ready_i(frm_ready), .frm_opcode_o(frm_opcode),
    .frm_addr_o(frm_addr), .frm_addr_bytes_o(frm_abytes), .frm_addr_lanes_o(frm_alanes),
    .frm_dummy_o(frm_dummy), .frm_data_lanes_o(frm_dlanes), .frm_data_len_o(frm_len),
    .frm_rx_valid_i(frm_rx_valid), .frm_rx_data_i(frm_rx_data), .frm_end_i(frm_end),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .done_o(done), .code_o(code)
  );

  int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
  bit in_cache = 0, exp_done = 0;
  int exp_code = 0;
  int rd_total = 0, rd_base = 0, seed = 0;

  function automatic logic [7:0] dbyte(int k);
    return 8'(k * 37 + seed);
  endfunction

  task automatic chk_eq(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // per-clock reference comparison of stream and completion outputs
  always @(posedge clk) begin
    if (rst_n) begin
      m_chk++;
      if (rd_valid !== (frm_rx_valid && in_cache)) begin
        m_err++;
        $display("FAIL R9 rd_valid: actual %0b expected %0b", rd_valid, frm_rx_valid && in_cache);
      end
      if (rd_valid && in_cache) begin
        m_chk++;
        if (rd_data !== dbyte(rd_total - rd_base)) begin
          m_err++;
          $display("FAIL R9 rd_data: actual %0h expected %0h", rd_data, dbyte(rd_total - rd_base));
        end
        rd_total++;
      end
      m_chk++;
      if (done !== exp_done) begin
        m_err++;
        $display("FAIL R11 done: actual %0b expected %0b", done, exp_done);
      end
      m_chk++;
      if (done && exp_done && int'(code) != exp_code) begin
        m_err++;
        $display("FAIL R10 code: actual %0d expected %0d", code, exp_code);
      end else if (!done && code != 2'd0) begin
        m_err++;
        $display("FAIL R11 code idle: actual %0d expected 0", code);
      end
    end
  end

  task automatic exp_var(input int m, output int op, output int al, output int dl);
    case (m)
      1: begin op = 'h0b; al = 1; dl = 1; end
      2: begin op = 'h3b; al = 1; dl = 2; end
      3: begin op = 'h6b; al = 1; dl = 4; end
      4: begin op = 'hbb; al = 2; dl = 2; end
      5: begin op = 'heb; al = 4; dl = 4; end
      default: begin op = 'h03; al = 1; dl = 1; end
    endcase
  endtask

  task automatic frame(input int op, input int ad, input int ab, input int al, input int dm,
                       input int dl, input int ln, input int hold, input string rq, input string rq_dm);
    int w = 0;
    @(negedge clk);
    while (!frm_valid && w < 50) begin
      @(negedge clk);
      w++;
    end
    for (int h = 0; h <= hold; h++) begin
      if (h > 0) @(negedge clk);
      chk_eq(h > 0 ? "R12" : rq, "frame valid", int'(frm_valid), 1);
      chk_eq(h > 0 ? "R12" : rq, "opcode", int'(frm_opcode), op);
      chk_eq(h > 0 ? "R12" : rq, "address", int'(frm_addr), ad);
      chk_eq(h > 0 ? "R12" : rq, "address bytes", int'(frm_abytes), ab);
      chk_eq(h > 0 ? "R12" : rq, "address lanes", int'(frm_alanes), al);
      chk_eq(h > 0 ? "R12" : rq_dm, "dummy", int'(frm_dummy), dm);
      chk_eq(h > 0 ? "R12" : rq, "data lanes", int'(frm_dlanes), dl);
      chk_eq(h > 0 ? "R12" : rq, "data length", int'(frm_len), ln);
    end
    frm_ready = 1'b1;
    @(negedge clk);
    frm_ready = 1'b0;
  endtask

  task automatic run(input int mode, input logic [23:0] row, input logic [15:0] col, input int len,
                     input int busy_n, input int ecc, input logic [7:0] extra, input int lim,
                     input bit poke, input int hold);
    int eff, op, al, dl, dm;
    logic [7:0] xb;
    xb = extra & 8'hce;
    seed = int'(row[7:0]) ^ int'(col[7:0]);
    @(negedge clk);
    chk_eq("R1", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_row = row; req_col = col; req_len = LEN_W'(len);
    req_mode = 3'(mode); poll_lim = POLL_W'(lim);
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R1", "ready after accept", int'(req_ready), 0);
    frame('h13, int'(row), 3, 1, 0, 1, 0, hold, "R2", "R2");
    if (poke) begin
      req_valid = 1'b1; req_row = ~row; req_col = ~col; req_mode = 3'd5; req_len = '1;
      #1 chk_eq("R1", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    eff = (lim == 0) ? 1 : lim;
    for (int p = 1; p <= 40; p++) begin
      frame('h0f, 'hc0, 1, 1, 0, 1, 1, 0, p > 1 ? "R4" : "R3", "R3");
      frm_rx_valid = 1'b1;
      frm_rx_data  = (p <= busy_n) ? (8'h21 | xb) : (8'(ecc << 4) | xb);
      @(negedge clk);
      frm_rx_valid = 1'b0;
      frm_end = 1'b1;
      @(negedge clk);
      frm_end = 1'b0;
      if (p <= busy_n && p >= eff) begin
        exp_done = 1'b1; exp_code = 3;
        @(negedge clk);
        exp_done = 1'b0;
        chk_eq("R5", "busy reads before timeout", p, eff);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk_eq("R5", "no cache frame after timeout", int'(frm_valid), 0);
        end
        return;
      end
      if (p > busy_n) break;
    end
    exp_var(mode, op, al, dl);
    dm = ((mode < 6) ? mode : 0) + 2;
    frame(op, int'(col), 2, al, dm, dl, len, hold, "R6", "R7");
    in_cache = 1'b1;
    rd_base = rd_total;
    for (int i = 0; i < len; i++) begin
      frm_rx_valid = 1'b1;
      frm_rx_data  = dbyte(i);
      @(negedge clk);
      frm_rx_valid = 1'b0;
      if (i == 0) @(negedge clk);
    end
    frm_end = 1'b1;
    @(negedge clk);
    frm_end = 1'b0;
    in_cache = 1'b0;
    exp_done = 1'b1;
    exp_code = (ecc == 0) ? 0 : (ecc == 1) ? 1 : 2;
    @(negedge clk);
    exp_done = 1'b0;
    chk_eq("R8", "bytes streamed", rd_total - rd_base, len);
    chk_eq("R11", "idle after done", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R1", "reset ready", int'(req_ready), 1);
    chk_eq("R1", "reset frame valid", int'(frm_valid), 0);
    chk_eq("R11", "reset done", int'(done), 0);
    chk_eq("R9", "reset rd_valid", int'(rd_valid), 0);
    // mode, row, col, len, busy, ecc, extra, limit, poke, hold
    run(0, 24'h01a2b3, 16'h0010, 4, 0, 0, 8'h00, 5, 0, 0);  // R2 R3 R6 R10 code 0
    run(1, 24'h00ff00, 16'h0123, 3, 2, 1, 8'h0c, 5, 0, 1);  // R4 R10 corrected, R12 hold
    run(2, 24'h123456, 16'h0800, 5, 0, 2, 8'h00, 5, 0, 2);  // R10 uncorrectable still streams
    run(3, 24'h654321, 16'h0001, 2, 1, 3, 8'hc2, 5, 0, 0);  // R10 reserved code
    run(4, 24'hfedcba, 16'hffff, 6, 1, 0, 8'hc2, 5, 0, 0);  // R6 dual IO
    run(5, 24'h000001, 16'h0202, 1, 0, 1, 8'h00, 5, 0, 0);  // R6 quad IO
    run(6, 24'h0a0b0c, 16'h0033, 2, 0, 0, 8'h00, 5, 0, 0);  // R6 R7 fallback
    run(7, 24'h0c0b0a, 16'h0044, 2, 0, 0, 8'h00, 5, 0, 0);  // R6 R7 fallback
    run(0, 24'h111111, 16'h0055, 3, 2, 0, 8'h00, 3, 0, 0);  // R5 one below limit
    run(0, 24'h222222, 16'h0066, 3, 3, 0, 8'h00, 3, 0, 0);  // R5 timeout at limit
    run(1, 24'h333333, 16'h0077, 2, 1, 0, 8'h00, 0, 0, 0);  // R5 limit zero
    run(2, 24'h444444, 16'h0088, 2, 0, 1, 8'h00, 0, 0, 0);  // R5 limit zero, ready
    run(1, 24'h555555, 16'h0099, 3, 1, 0, 8'h00, 5, 1, 0);  // R1 request while busy
    run(0, 24'h666666, 16'h00aa, 0, 0, 0, 8'h00, 5, 0, 0);  // R8 zero length
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk + 1, n_err + m_err + 1);
    $finish;
  end
endmodule